// File: doc/BRIEF.md
# Flash Operation Completion Poller

This engine sits on the host side of a parallel flash interface. Once a program or erase command has been sent to the device by other logic, a single start pulse hands the wait over to this block. The block then works out when the device has finished, using one of three interchangeable methods. It can watch the polarity bit of status reads, watch whether the alternating bit keeps changing between two successive reads, or watch the shared ready/busy line. The block never drives addresses or commands. It only asks a bus master for reads through a request/valid handshake and examines the bytes that come back.

When a program operation completes, the block makes one last read and compares the whole byte with the value that was written, so a failed program is reported as an error. A cycle-limit counter, loaded at start, stops a poll that never ends. Done, timeout and error are levels that stay valid until the next accepted start.

Top module: `flash_done_poller`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `busy`, `rd_req`, `done`, `timeout` and `error` are all 0.
- R2: A `start` seen in a clock edge while `busy` is 0 latches `mode`, `is_erase`, `expect_data` and `timeout_limit`, clears the three result flags and sets `busy` after that edge. In the two read-based modes `rd_req` is 1 from that same edge, so no wait is inserted before the first read.
- R3: Mode encoding: `mode` 0 is polarity polling, 1 is alternating-bit polling, 2 and 3 are ready/busy. A read beat is a rising edge with `rd_req` and `rd_valid` both 1, and `rd_data` is sampled on it. In polarity mode for a program (`is_erase`=0), a beat ends the poll when bit 7 of `rd_data` equals bit 7 of `expect_data`.
- R4: In polarity mode for an erase (`is_erase`=1), a beat ends the poll when bit 7 of `rd_data` is 1. An erase finishes with `done` and no further read.
- R5: In alternating-bit mode, the first beat after start is only stored. Each later beat ends the poll when its bit 6 equals bit 6 of the beat before it. Otherwise that beat is stored in turn.
- R6: In ready/busy mode, `rb_n` (0 = busy, 1 = ready, a shared wired line) passes through two flops. The poll ends on the first edge at which the second flop holds 1. No read is requested while waiting.
- R7: For a program, the end of the poll is followed by exactly one verify read. On its beat `done` becomes 1, and `error` becomes 1 when the full `rd_data` differs from `expect_data`.
- R8: With a nonzero `timeout_limit` L, an operation not finished by the edge that ends its L-th busy cycle stops on that edge with `timeout`=1 and `busy`=`rd_req`=0. A finish on that same edge takes priority. L = 0 disables the limit.
- R9: A `start` while `busy` is 1 is ignored and changes neither the operation in progress nor its parameters.
- R10: `done`, `timeout` and `error` hold their values from the end of an operation until the next accepted start. `done` and `timeout` are never 1 together, and `error` is only 1 together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin watching an operation |
| mode | input | 2 | Detection method: 0 polarity, 1 alternating bit, 2/3 ready/busy |
| is_erase | input | 1 | 1 for an erase, 0 for a program |
| expect_data | input | DW | Value written by the program operation |
| timeout_limit | input | TW | Busy-cycle limit, 0 = no limit |
| rd_req | output | 1 | Read request to the bus master |
| rd_valid | input | 1 | Read data valid, completes a beat with rd_req |
| rd_data | input | DW | Data returned by the read |
| rb_n | input | 1 | Asynchronous ready/busy line, low = busy |
| busy | output | 1 | An operation is being watched |
| done | output | 1 | Operation finished |
| timeout | output | 1 | Limit reached before finish |
| error | output | 1 | Verify read differed from expected data |

## Verification
A wrong control state shows up at the ports in the very next cycle: `rd_req` appears when it should be absent, for example during a ready/busy wait or after an erase finishes, or `busy` stays high one beat too long or drops one beat too early. A corrupted stored previous byte or latched expected value moves the finishing beat to a different read. That changes the number of reads taken and the cycle at which `done` rises. A timer that is off by one shows as one busy cycle too many or too few at the limit.

// File: rtl/poll_pkg.sv
package poll_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_POLL   = 2'd1,
    ST_RBWAIT = 2'd2,
    ST_VERIFY = 2'd3
  } poll_st_t;

  localparam logic [1:0] MODE_POLARITY = 2'd0;
  localparam logic [1:0] MODE_ALTBIT   = 2'd1;
endpackage

// File: rtl/poll_sync.sv
module poll_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/poll_judge.sv
module poll_judge #(
  parameter int DW     = 8,
  parameter int DP_BIT = 7,
  parameter int TG_BIT = 6
) (
  input  logic          use_alt,
  input  logic          erase_op,
  input  logic          have_prev,
  input  logic [DW-1:0] exp_val,
  input  logic [DW-1:0] prev_val,
  input  logic [DW-1:0] rdata,
  output logic          complete,
  output logic          mismatch
);
  logic pol_hit;
  logic alt_hit;

  always_comb begin
    if (erase_op) pol_hit = rdata[DP_BIT];
    else          pol_hit = (rdata[DP_BIT] == exp_val[DP_BIT]);
    alt_hit  = have_prev && (rdata[TG_BIT] == prev_val[TG_BIT]);
    complete = use_alt ? alt_hit : pol_hit;
    mismatch = (rdata != exp_val);
  end
endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (clear) cnt <= '0;
    else if (run)   cnt <= cnt + 1'b1;
  end

  assign expire = run && (limit != '0) && (cnt == limit - 1'b1);
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
  import poll_pkg::*;
#(
  parameter int DW          = 8,
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DP_BIT      = 7,
  parameter int TG_BIT      = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic          is_erase,
  input  logic [DW-1:0] expect_data,
  input  logic [TW-1:0] timeout_limit,
  output logic          rd_req,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  input  logic          rb_n,
  output logic          busy,
  output logic          done,
  output logic          timeout,
  output logic          error
);
  poll_st_t      state;
  logic          alt_q;
  logic          erase_q;
  logic [DW-1:0] exp_q;
  logic [DW-1:0] prev_q;
  logic          have_q;
  logic [TW-1:0] lim_q;
  logic          done_q;
  logic          to_q;
  logic          err_q;

  logic rb_s;
  logic complete;
  logic mismatch;
  logic expire;
  logic beat;
  logic accept;
  logic detect;
  logic finish;
  logic go_verify;

  poll_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (rb_n),
    .q   (rb_s)
  );

  poll_judge #(.DW(DW), .DP_BIT(DP_BIT), .TG_BIT(TG_BIT)) u_judge (
    .use_alt   (alt_q),
    .erase_op  (erase_q),
    .have_prev (have_q),
    .exp_val   (exp_q),
    .prev_val  (prev_q),
    .rdata     (rd_data),
    .complete  (complete),
    .mismatch  (mismatch)
  );

  poll_timer #(.TW(TW)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .clear  (accept),
    .run    (state != ST_IDLE),
    .limit  (lim_q),
    .expire (expire)
  );

  always_comb begin
    rd_req    = (state == ST_POLL) || (state == ST_VERIFY);
    busy      = (state != ST_IDLE);
    beat      = rd_req && rd_valid;
    accept    = (state == ST_IDLE) && start;
    detect    = ((state == ST_POLL) && beat && complete) ||
                ((state == ST_RBWAIT) && rb_s);
    finish    = ((state == ST_VERIFY) && beat) || (detect && erase_q);
    go_verify = detect && !erase_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      alt_q   <= 1'b0;
      erase_q <= 1'b0;
      exp_q   <= '0;
      prev_q  <= '0;
      have_q  <= 1'b0;
      lim_q   <= '0;
      done_q  <= 1'b0;
      to_q    <= 1'b0;
      err_q   <= 1'b0;
    end else if (state == ST_IDLE) begin
      if (start) begin
        alt_q   <= (mode == MODE_ALTBIT);
        erase_q <= is_erase;
        exp_q   <= expect_data;
        lim_q   <= timeout_limit;
        have_q  <= 1'b0;
        done_q  <= 1'b0;
        to_q    <= 1'b0;
        err_q   <= 1'b0;
        state   <= mode[1] ? ST_RBWAIT : ST_POLL;
      end
    end else if (finish) begin
      state  <= ST_IDLE;
      done_q <= 1'b1;
      err_q  <= (state == ST_VERIFY) && mismatch;
    end else if (expire) begin
      state <= ST_IDLE;
      to_q  <= 1'b1;
    end else if (go_verify) begin
      state <= ST_VERIFY;
    end else if ((state == ST_POLL) && beat) begin
      prev_q <= rd_data;
      have_q <= 1'b1;
    end
  end

  assign done    = done_q;
  assign timeout = to_q;
  assign error   = err_q;
endmodule

// File: rtl/poll_checks.sv
module poll_checks (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic rd_req,
  input logic done,
  input logic timeout,
  input logic error
);
  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  a_r2_req_only_busy: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> busy);

  a_r8_timeout_idle: assert property (@(posedge clk) disable iff (rst)
    timeout |-> (!busy && !rd_req));

  a_r10_flags_excl: assert property (@(posedge clk) disable iff (rst)
    !(done && timeout));

  a_r7_error_with_done: assert property (@(posedge clk) disable iff (rst)
    error |-> done);

  a_r10_flags_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(done) && $stable(timeout) && $stable(error)));

  a_r10_end_reports: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done || timeout));
endmodule

bind flash_done_poller poll_checks u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .rd_req  (rd_req),
  .done    (done),
  .timeout (timeout),
  .error   (error)
);

// File: tb/sim_flash_done_poller.sv
module sim_flash_done_poller;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        is_erase = 1'b0;
  logic [7:0]  expect_data = 8'h00;
  logic [15:0] timeout_limit = 16'd0;
  logic        rd_req;
  logic        rd_valid = 1'b1;
  logic [7:0]  rd_data = 8'h00;
  logic        rb_n = 1'b0;
  logic        busy, done, timeout, error;

  int errors = 0;
  int checks = 0;
  int beats  = 0;
  bit stall_en = 0;
  int cyc = 0;
  string cur_req = "R1";
  logic [7:0] q[$];

  // reference model state
  int         m_state = 0;   // 0 idle, 1 poll, 2 rb wait, 3 verify
  int         m_cnt = 0;
  logic [1:0] m_md;
  logic       m_er;
  logic [7:0] m_exp, m_prev;
  logic [15:0] m_lim;
  bit         m_have, m_done, m_to, m_err, m_s1, m_s2;
  bit         mb, mcmp, mfin, msv, mtov;
  logic [7:0] md;

  always #5 clk = ~clk;

  flash_done_poller u0 (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .is_erase(is_erase),
    .expect_data(expect_data), .timeout_limit(timeout_limit),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data), .rb_n(rb_n),
    .busy(busy), .done(done), .timeout(timeout), .error(error)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // read-side responder
  always @(negedge clk) begin
    cyc++;
    rd_valid = stall_en ? ((cyc % 3) != 0) : 1'b1;
    rd_data  = (q.size() > 0) ? q[0] : 8'h00;
  end

  always @(posedge clk) if (!rst && rd_req && rd_valid) beats++;

  // behavioural reference, advanced on every edge
  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_cnt = 0; m_have = 0; m_done = 0; m_to = 0; m_err = 0;
      m_s1 = 0; m_s2 = 0; m_prev = 0;
    end else begin
      msv = m_s2; m_s2 = m_s1; m_s1 = rb_n;
      mb = ((m_state == 1) || (m_state == 3)) && rd_valid;
      md = rd_data;
      if (mb && q.size() > 0) void'(q.pop_front());
      if (m_state == 0) begin
        if (start) begin
          m_md = mode; m_er = is_erase; m_exp = expect_data; m_lim = timeout_limit;
          m_have = 0; m_done = 0; m_to = 0; m_err = 0; m_cnt = 0;
          m_state = (mode >= 2) ? 2 : 1;
        end
      end else begin
        mfin = 0; mtov = 0; mcmp = 0;
        if (m_state == 1 && mb) begin
          if (m_md == 1)  mcmp = m_have && (md[6] == m_prev[6]);
          else if (m_er)  mcmp = md[7];
          else            mcmp = (md[7] == m_exp[7]);
        end
        if (m_state == 2) mcmp = msv;
        if (m_state == 3 && mb) begin
          mfin = 1; m_err = (md != m_exp);
        end else if (mcmp) begin
          if (m_er) mfin = 1; else mtov = 1;
        end
        if (mfin) begin
          m_state = 0; m_done = 1;
        end else if (m_lim != 0 && m_cnt == int'(m_lim) - 1) begin
          m_state = 0; m_to = 1;
        end else begin
          m_cnt++;
          if (mtov) m_state = 3;
          else if (m_state == 1 && mb) begin m_prev = md; m_have = 1; end
        end
      end
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst) begin
      chk({cur_req, " busy"},    busy,    m_state != 0);
      chk({cur_req, " rd_req"},  rd_req,  (m_state == 1) || (m_state == 3));
      chk({cur_req, " done"},    done,    m_done);
      chk({cur_req, " timeout"}, timeout, m_to);
      chk({cur_req, " error"},   error,   m_err);
    end
  end

  task automatic kick(input logic [1:0] md_i, input logic er, input logic [7:0] ex,
                      input logic [15:0] lim);
    @(negedge clk);
    mode = md_i; is_erase = er; expect_data = ex; timeout_limit = lim; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy after start", busy, 1'b1);
    chk("R2 no initial wait", rd_req, (md_i < 2) ? 1'b1 : 1'b0);
  endtask

  task automatic wait_idle(output int bc);
    bc = 1;
    while (busy && bc < 5000) begin
      @(negedge clk);
      if (busy) bc++;
    end
  endtask

  initial begin
    int bc;
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);   chk("R1 rd_req", rd_req, 0);
    chk("R1 done", done, 0);   chk("R1 timeout", timeout, 0);
    chk("R1 error", error, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", {busy, rd_req, done, timeout, error}, 5'b0);

    // R3 polarity program, with stalls
    cur_req = "R3"; stall_en = 1;
    q = '{8'h25, 8'h25, 8'hA5, 8'hA5};
    beats = 0;
    kick(2'd0, 1'b0, 8'hA5, 16'd0); wait_idle(bc);
    chk("R3 done", done, 1); chk("R3 no error", error, 0); chk("R3 reads", beats, 4);
    stall_en = 0;

    // R7 verify mismatch
    cur_req = "R7";
    q = '{8'h00, 8'h80, 8'h84};
    beats = 0;
    kick(2'd0, 1'b0, 8'h80, 16'd0); wait_idle(bc);
    chk("R7 done", done, 1); chk("R7 error", error, 1); chk("R7 reads", beats, 3);

    // R10 flags hold while idle
    cur_req = "R10";
    repeat (6) @(negedge clk);
    chk("R10 done held", done, 1); chk("R10 error held", error, 1);

    // R4 polarity erase, no verify read
    cur_req = "R4";
    q = '{8'h00, 8'h7F, 8'hFF};
    beats = 0;
    kick(2'd0, 1'b1, 8'h00, 16'd0); wait_idle(bc);
    chk("R4 done", done, 1); chk("R10 error cleared by start", error, 0);
    chk("R4 reads", beats, 3); chk("R4 no extra read", rd_req, 0);

    // R5 alternating bit, program
    cur_req = "R5";
    q = '{8'h40, 8'h00, 8'h40, 8'h40, 8'h3C};
    beats = 0;
    kick(2'd1, 1'b0, 8'h3C, 16'd0); wait_idle(bc);
    chk("R5 done", done, 1); chk("R5 no error", error, 0); chk("R5 reads", beats, 5);

    // R5 alternating bit, erase: second read equals first
    q = '{8'h00, 8'h00};
    beats = 0;
    kick(2'd1, 1'b1, 8'h00, 16'd0); wait_idle(bc);
    chk("R5 erase done", done, 1); chk("R5 erase reads", beats, 2);

    // R6 ready/busy, program with verify
    cur_req = "R6";
    rb_n = 1'b0;
    q = '{8'h11};
    beats = 0;
    kick(2'd2, 1'b0, 8'h11, 16'd0);
    repeat (8) @(negedge clk);
    chk("R6 still busy", busy, 1); chk("R6 no reads while waiting", beats, 0);
    rb_n = 1'b1;
    wait_idle(bc);
    chk("R6 done", done, 1); chk("R6 only verify read", beats, 1);
    chk("R6 no error", error, 0);

    // R9 start while busy is ignored
    cur_req = "R9";
    rb_n = 1'b0;
    q = '{8'h5A};
    beats = 0;
    kick(2'd3, 1'b0, 8'h5A, 16'd0);
    @(negedge clk);
    mode = 2'd0; is_erase = 1'b1; expect_data = 8'hFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 no reads started", beats, 0);
    rb_n = 1'b1;
    wait_idle(bc);
    chk("R9 original op done", done, 1); chk("R9 original expect", error, 0);
    rb_n = 1'b0;

    // R8 timeout at limit 5
    cur_req = "R8";
    q.delete();
    kick(2'd0, 1'b0, 8'h80, 16'd5); wait_idle(bc);
    chk("R8 timeout", timeout, 1); chk("R8 not done", done, 0);
    chk("R8 busy cycles", bc, 5);

    // R8 limit 0 disables
    for (int i = 0; i < 40; i++) q.push_back(8'h00);
    q.push_back(8'hFF);
    beats = 0;
    kick(2'd0, 1'b1, 8'h00, 16'd0); wait_idle(bc);
    chk("R8 no limit done", done, 1); chk("R8 no limit timeout", timeout, 0);
    chk("R8 no limit reads", beats, 41);

    // R8 finish on the limit edge wins: limit 3, third read completes erase
    q = '{8'h00, 8'h00, 8'h80};
    kick(2'd0, 1'b1, 8'h00, 16'd3); wait_idle(bc);
    chk("R8 finish priority done", done, 1); chk("R8 finish priority timeout", timeout, 0);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule